// File: doc/BRIEF.md
# Burst Address Counter with Readback

This block generates the address for one port of a 32K-deep synchronous memory. On each rising clock edge it either takes a new 15-bit start address from outside, or steps its internal count by one for a burst, or clears, or holds. The internal count is driven straight to the memory array as the address. A controller can therefore issue one start address and then stream consecutive locations by keeping the count enable high.

A readback mode lets the port's data output carry the counter's present value, zero-extended to the data bus width, in place of memory data. The counter holds while this mode is active, so the value read back is stable. The block also emits a one-cycle step signal in every cycle in which an increment is applied. A neighbouring bus-matching sub-word sequencer uses it as a carry-in, so it only moves on to later sub-words while a burst is advancing.

Top module: `bac_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter is set to 0. After reset, with all controls low, `mem_addr` reads 0x0000 and `sub_step` is 0.
- R2: When `addr_stb` and `cnt_en` are both high and `cnt_clr` is low at a rising edge, `ext_addr` is loaded into the counter. `addr_stb` alone, with `cnt_en` low, loads nothing and the counter holds.
- R3: When `cnt_clr` is high at a rising edge, the counter becomes 0x0000. This takes priority over load, readback and increment.
- R4: When `cnt_en` is high, and `addr_stb`, `cnt_clr` and `rdbk` are low, at a rising edge, the counter increases by one. It wraps from 0x7FFF to 0x0000.
- R5: While `rdbk` is high, `dout` equals the counter value zero-extended to 36 bits, so bits 35..15 are 0. While `rdbk` is low, `dout` equals `mem_rdata`. The output is combinational within the cycle.
- R6: While `rdbk` is high and no clear or load applies, the counter holds even if `cnt_en` is high. A clear or a load still takes effect during readback.
- R7: When `cnt_en` and `cnt_clr` are low at a rising edge, the counter holds and `ext_addr` has no effect.
- R8: `sub_step` is 1 in exactly those cycles whose controls make the next rising edge apply an increment (the R4 condition), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | 15 | External start address |
| addr_stb | input | 1 | Address strobe, loads only with cnt_en |
| cnt_en | input | 1 | Count enable |
| cnt_clr | input | 1 | Synchronous counter clear |
| rdbk | input | 1 | Readback mode: hold counter, show it on dout |
| mem_rdata | input | 36 | Data from the memory array |
| mem_addr | output | 15 | Current counter value, address to the array |
| dout | output | 36 | Port data out: array data or counter readback |
| sub_step | output | 1 | Carry-in for the sub-word sequencer |

## Verification
Directed sequences test the control priorities one at a time:
- clear against a strobe, which tells R3 apart from R2;
- strobe without enable, which tells R2 apart from R7;
- readback with enable high, which tells R6 apart from R4;
- a load near the top of the range followed by two increments, which exposes a missing wrap.

Constrained random control mixes, with clear kept rare and the strobe common, then cover long bursts, reloads in mid-burst and readback windows. These runs are compared each cycle against a bench model of the next count, the step signal and the data output.

// File: rtl/bac_pkg.sv
// Package bac_pkg
// Shared types for the burst address counter. The operation code is the
// single decision the control decoder hands to the count register.
package bac_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_FREEZE = 3'd4
    } bac_op_e;
endpackage

// File: rtl/bac_ctrl.sv
// Module bac_ctrl
// Resolves the control inputs into one operation with a fixed priority:
// clear, then load (strobe with enable), then readback freeze, then
// increment, else hold. Assumes all inputs are already synchronous to clk.
module bac_ctrl
    import bac_pkg::*;
(
    input  logic    addr_stb,
    input  logic    cnt_en,
    input  logic    cnt_clr,
    input  logic    rdbk,
    output bac_op_e op,
    output logic    step
);
    // Priority decode of the controls
    always_comb begin
        if (cnt_clr)                 op = OP_CLEAR;
        else if (addr_stb && cnt_en) op = OP_LOAD;
        else if (rdbk)               op = OP_FREEZE;
        else if (cnt_en)             op = OP_INC;
        else                         op = OP_HOLD;
    end

    // Carry-in for the sub-word sequencer: only on a real increment
    always_comb begin
        step = (op == OP_INC);
    end
endmodule

// File: rtl/bac_counter.sv
// Module bac_counter
// Holds the burst count. It applies the decoded operation on the rising
// edge and wraps modulo 2**ADDR_W. Assumes rst_n is synchronous and
// active low.
module bac_counter
    import bac_pkg::*;
#(
    parameter int ADDR_W = 15
)(
    input  logic              clk,
    input  logic              rst_n,
    input  bac_op_e           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] cnt_q
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] cnt_d;

    // Next-count selection
    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_d = '0;
            OP_LOAD:  cnt_d = load_val;
            OP_INC:   cnt_d = cnt_q + ONE;
            default:  cnt_d = cnt_q;
        endcase
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bac_rdbk_mux.sv
// Module bac_rdbk_mux
// Chooses the port data output: array data normally, or the counter
// value fitted to the data width while readback is on. A wider bus is
// zero-extended. A narrower one (not expected) keeps the low bits.
module bac_rdbk_mux #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36
)(
    input  logic              rdbk,
    input  logic [ADDR_W-1:0] cnt_q,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] cnt_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-extend the counter to the bus width
            always_comb cnt_ext = {{PAD_W{1'b0}}, cnt_q};
        end else begin : g_trunc
            // Keep the low bits of the counter
            always_comb cnt_ext = cnt_q[DATA_W-1:0];
        end
    endgenerate

    // Output selection
    always_comb begin
        dout = rdbk ? cnt_ext : mem_rdata;
    end
endmodule

// File: rtl/bac_top.sv
// Module bac_top
// Per-port burst address counter with readback and a sub-word step
// output. Assumes ADDR_W <= DATA_W and that the controls are stable
// around the rising edge.
module bac_top #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              addr_stb,
    input  logic              cnt_en,
    input  logic              cnt_clr,
    input  logic              rdbk,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dout,
    output logic              sub_step
);
    import bac_pkg::*;

    bac_op_e           op;
    logic [ADDR_W-1:0] cnt_q;

    bac_ctrl u_ctrl (
        .addr_stb (addr_stb),
        .cnt_en   (cnt_en),
        .cnt_clr  (cnt_clr),
        .rdbk     (rdbk),
        .op       (op),
        .step     (sub_step)
    );

    bac_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (ext_addr),
        .cnt_q    (cnt_q)
    );

    bac_rdbk_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .rdbk      (rdbk),
        .cnt_q     (cnt_q),
        .mem_rdata (mem_rdata),
        .dout      (dout)
    );

    // Address to the array is the live count
    always_comb mem_addr = cnt_q;
endmodule

// File: rtl/bac_chk.sv
// Module bac_chk
// Temporal checks on the counter's ports, bound into bac_top.
module bac_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36
)(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              addr_stb,
    input logic              cnt_en,
    input logic              cnt_clr,
    input logic              rdbk,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] dout,
    input logic              sub_step
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (mem_addr == '0)); // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && cnt_en && !cnt_clr) |=> (mem_addr == $past(ext_addr))); // R2
    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !addr_stb && !cnt_clr && !rdbk) |=> (mem_addr == $past(mem_addr) + ONE)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(mem_addr)); // R7
    AST_RDBK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdbk && !cnt_clr && !(addr_stb && cnt_en)) |=> $stable(mem_addr)); // R6
    AST_RDBK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdbk |-> (dout[DATA_W-1:ADDR_W] == '0)); // R5
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        sub_step |=> (mem_addr == $past(mem_addr) + ONE)); // R8
    AST_STEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr || rdbk || !cnt_en) |-> !sub_step); // R8
endmodule

bind bac_top bac_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .addr_stb (addr_stb),
    .cnt_en   (cnt_en),
    .cnt_clr  (cnt_clr),
    .rdbk     (rdbk),
    .mem_addr (mem_addr),
    .dout     (dout),
    .sub_step (sub_step)
);

// File: tb/bac_top_tb.sv
// Bench for bac_top: directed corner cases, then seeded random control mixes.
module bac_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          addr_stb, cnt_en, cnt_clr, rdbk;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] dout;
    logic          sub_step;

    int errors = 0;
    int checks = 0;
    logic [AW-1:0] exp_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    bac_top u_dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .addr_stb(addr_stb),
        .cnt_en(cnt_en), .cnt_clr(cnt_clr), .rdbk(rdbk), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .dout(dout), .sub_step(sub_step)
    );

    // Next count implied by the requirements
    function automatic logic [AW-1:0] model_next(input logic [AW-1:0] c,
            input logic [AW-1:0] a, input logic s, input logic e,
            input logic cl, input logic rb);
        if (cl)         return '0;          // R3
        if (s && e)     return a;           // R2
        if (rb)         return c;           // R6
        if (e)          return c + 1'b1;    // R4
        return c;                           // R7
    endfunction

    function automatic logic model_step(input logic s, input logic e,
            input logic cl, input logic rb);
        return e && !s && !cl && !rb;       // R8
    endfunction

    function automatic logic [DW-1:0] model_dout(input logic [AW-1:0] c,
            input logic rb, input logic [DW-1:0] m);
        return rb ? {{(DW-AW){1'b0}}, c} : m;  // R5
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check the combinational outputs,
    // then check the count after the rising edge
    task automatic cycle(input string req, input logic [AW-1:0] a, input logic s,
            input logic e, input logic cl, input logic rb, input logic [DW-1:0] m);
        @(negedge clk);
        ext_addr = a; addr_stb = s; cnt_en = e; cnt_clr = cl; rdbk = rb; mem_rdata = m;
        #1;
        check({req, " dout"}, dout, model_dout(exp_cnt, rb, m));
        check({req, " step"}, {35'd0, sub_step}, {35'd0, model_step(s, e, cl, rb)});
        exp_cnt = model_next(exp_cnt, a, s, e, cl, rb);
        @(posedge clk);
        #1;
        check({req, " addr"}, {21'd0, mem_addr}, {21'd0, exp_cnt});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 1'b0; ext_addr = 15'h1234; addr_stb = 0; cnt_en = 1; cnt_clr = 0;
        rdbk = 0; mem_rdata = 36'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; cnt_en = 0;
        exp_cnt = '0;
        #1;
        check("R1 reset addr", {21'd0, mem_addr}, 36'd0);
        check("R1 reset step", {35'd0, sub_step}, 36'd0);

        // Load and simple burst
        cycle("R2 load", 15'h0100, 1, 1, 0, 0, 36'hA_BCDE_F012);
        cycle("R4 inc", 15'h7777, 0, 1, 0, 0, 36'h1);
        cycle("R4 inc", 15'h7777, 0, 1, 0, 0, 36'h2);
        // Strobe without enable: ignored
        cycle("R2 stb only", 15'h0ABC, 1, 0, 0, 0, 36'h3);
        // Idle with changing address: ignored
        cycle("R7 hold", 15'h5555, 0, 0, 0, 0, 36'h4);
        // Wrap
        cycle("R2 load top", 15'h7FFE, 1, 1, 0, 0, 36'h5);
        cycle("R4 inc", 15'h0, 0, 1, 0, 0, 36'h6);
        cycle("R4 wrap", 15'h0, 0, 1, 0, 0, 36'h7);
        // Readback freezes increment
        cycle("R2 load", 15'h2468, 1, 1, 0, 0, 36'h8);
        cycle("R6 rdbk freeze", 15'h0, 0, 1, 0, 1, 36'hF_FFFF_FFFF);
        cycle("R5 rdbk", 15'h0, 0, 0, 0, 1, 36'hF_FFFF_FFFF);
        cycle("R6 rdbk load", 15'h7ABC, 1, 1, 0, 1, 36'hF_0F0F_0F0F);
        cycle("R5 rdbk top", 15'h0, 0, 0, 0, 1, 36'h9);
        // Clear beats load
        cycle("R3 clr over load", 15'h3333, 1, 1, 1, 0, 36'hA);
        cycle("R2 load", 15'h1111, 1, 1, 0, 0, 36'hB);
        cycle("R3 clr in rdbk", 15'h0, 0, 1, 1, 1, 36'hC);

        // Random mixes
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] m;
            logic s, e, cl, rb;
            a  = AW'($urandom);
            m  = {4'($urandom), 32'($urandom)};
            s  = ($urandom % 4) == 0;
            e  = ($urandom % 4) != 0;
            cl = ($urandom % 32) == 0;
            rb = ($urandom % 6) == 0;
            cycle("R8 random", a, s, e, cl, rb, m);
        end

        // Reset mid-burst
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1; addr_stb = 0; cnt_clr = 0; rdbk = 0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        exp_cnt = '0;
        check("R1 reset mid", {21'd0, mem_addr}, 36'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule